// File: doc/BRIEF.md
# Round-Robin Comparator Channel Scanner

This block steps a single analog comparator through a set of up to `NUM_CH` input channels. One comparator port stays on a chosen reference channel. The other port visits every enabled channel in turn. The sweep advances only on a round-robin tick strobe (`rr_tick`), which is qualified against the system clock. After a programmable start-up wait, each visited channel stays selected for a programmable number of ticks so the analog path can settle. On the last of those ticks the comparator's decision is latched into that channel's result bit.

Each channel also keeps a sticky changed flag. The flag is set whenever a new decision for that channel differs from the one stored for it. Software clears a flag by pulsing its bit on `flag_clr`. An interrupt line reports any pending flag while it is enabled. The analog multiplexers, the reference DAC and the register file that holds the configuration are outside this block. The block only produces mux select codes and consumes the comparator's digital result.

Top module: `rr_cmp_scanner`

## Requirements
- R1: Scanning takes place only while `scan_en` is 1. When `scan_en` is 0 the block is idle: ticks change neither `result` nor the swept select, and the start-up wait is reset.
- R2: Let k count the ticks seen since `scan_en` last rose, starting at 1. Let M be the start-up modulus. The lowest enabled channel appears on the swept port after tick M+1, and no sample is taken before then.
- R3: The swept port visits only channels whose `ch_mask` bit is 1. It visits them in ascending index order and wraps from the highest enabled channel to the lowest.
- R4: With `hold_minus` = 0, `plus_sel` equals `ref_ch` and `minus_sel` carries the swept channel. With `hold_minus` = 1, `minus_sel` equals `ref_ch` and `plus_sel` carries the swept channel.
- R5: Each visited channel stays on the swept port for `settle`+1 ticks. The swept select changes only on a tick.
- R6: `result[i]` takes the value of `cmp_in` on the last tick of channel i's visit. All other result bits keep their value. At most one bit changes per clock.
- R7: `chg_flag[i]` is set when the value sampled for channel i differs from `result[i]` as it stood before that sample.
- R8: A 1 on `flag_clr[i]` for one clock clears `chg_flag[i]`. If a set for the same channel happens in that clock, the set wins.
- R9: `irq` is 1 exactly when `irq_en` is 1 and at least one changed flag is 1.
- R10: If `ch_mask` is all zero, the scanner stays idle. `result`, `chg_flag` and the swept select do not change.
- R11: After reset, `result`, `chg_flag` and `irq` are 0 and the swept select is channel 0.
- R12: An `init_mod` value of 0 gives a start-up modulus M of 2^`INIT_W` ticks (64 by default). Any other value is used as M directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_tick | input | 1 | Round-robin step strobe, one clock wide |
| scan_en | input | 1 | Enables scanning; a fresh rise restarts the start-up wait |
| ch_mask | input | NUM_CH | Per-channel inclusion in the sweep |
| ref_ch | input | CH_W | Reference channel for the held port |
| hold_minus | input | 1 | 0 holds the plus port, 1 holds the minus port |
| settle | input | DLY_W | Extra settling ticks per channel |
| init_mod | input | INIT_W | Start-up wait in ticks, 0 meaning 2^INIT_W |
| cmp_in | input | 1 | Comparator decision for the current selection |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | NUM_CH | Write-one-to-clear strobes for the changed flags |
| plus_sel | output | CH_W | Plus-port mux select code |
| minus_sel | output | CH_W | Minus-port mux select code |
| result | output | NUM_CH | Latest decision per channel |
| chg_flag | output | NUM_CH | Sticky changed flag per channel |
| irq | output | 1 | Interrupt request |

## Verification
Suppose the step position or the settle counter drifts. The swept select code then shows a wrong channel from the next tick on. A decision is also written into a neighbouring result bit one visit later, and a spurious changed flag follows. A start-up counter that miscounts moves the first appearance of the lowest channel by whole ticks. The bench therefore compares the select codes, the result vector, the flags and `irq` after every tick, against a tick-index formula over masks, settle depths, moduli and both port polarities.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

   // which comparator port is pinned to the reference channel
   typedef enum logic {
      HOLD_PLUS  = 1'b0,
      HOLD_MINUS = 1'b1
   } hold_e;

   // sequencer phase
   typedef enum logic {
      PH_OFF  = 1'b0,
      PH_SCAN = 1'b1
   } phase_e;

endpackage

// File: rtl/rrs_init_timer.sv
// Start-up wait: counts ticks after run rises, ready once the modulus is reached.
module rrs_init_timer #(
   parameter int INIT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run,
   input  logic [INIT_W-1:0] init_mod,
   output logic              ready
);
   localparam int CNT_W = INIT_W + 1;
   localparam logic [CNT_W-1:0] FULL_MOD = CNT_W'(2 ** INIT_W);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mod_eff;
   logic             ready_q;

   always_comb begin
      if (init_mod == '0) mod_eff = FULL_MOD;
      else                mod_eff = {1'b0, init_mod};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ready_q <= 1'b0;
      end else if (!run) begin
         cnt_q   <= '0;
         ready_q <= 1'b0;
      end else if (tick && !ready_q) begin
         if (cnt_q == mod_eff - 1'b1) ready_q <= 1'b1;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ready = ready_q;

endmodule

// File: rtl/rrs_picker.sv
// Finds the lowest enabled channel and the next enabled channel after cur.
module rrs_picker #(
   parameter int NUM_CH = 8,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [CH_W-1:0]   cur,
   output logic [CH_W-1:0]   first_idx,
   output logic [CH_W-1:0]   next_idx,
   output logic              any
);
   logic            first_found;
   logic            next_found;
   logic [CH_W-1:0] probe;

   assign any = |mask;

   always_comb begin
      first_idx   = '0;
      first_found = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (mask[i] && !first_found) begin
            first_idx   = CH_W'(i);
            first_found = 1'b1;
         end
      end
   end

   // ring search starting one above cur; index wraps through CH_W bits
   always_comb begin
      next_idx   = cur;
      next_found = 1'b0;
      probe      = cur;
      for (int o = 1; o <= NUM_CH; o++) begin
         probe = cur + CH_W'(o);
         if (mask[probe] && !next_found) begin
            next_idx   = probe;
            next_found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/rrs_sequencer.sv
// Holds the swept channel and the settle count; issues the sample strobe.
module rrs_sequencer
   import rrs_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CH_W   = $clog2(NUM_CH),
   parameter int DLY_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run,
   input  logic              ready,
   input  logic [NUM_CH-1:0] mask,
   input  logic [DLY_W-1:0]  settle,
   input  logic [CH_W-1:0]   first_idx,
   input  logic [CH_W-1:0]   next_idx,
   input  logic              any,
   output logic [CH_W-1:0]   cur,
   output logic              sample_stb
);
   phase_e           phase_q;
   logic [CH_W-1:0]  cur_q;
   logic [DLY_W-1:0] dly_q;
   logic             last_tick;

   assign last_tick = (dly_q == settle);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         cur_q   <= '0;
         dly_q   <= '0;
      end else if (!run) begin
         phase_q <= PH_OFF;
         dly_q   <= '0;
      end else if (tick) begin
         unique case (phase_q)
            PH_OFF: begin
               if (ready && any) begin
                  phase_q <= PH_SCAN;
                  cur_q   <= first_idx;
                  dly_q   <= '0;
               end
            end
            PH_SCAN: begin
               if (any) begin
                  if (last_tick) begin
                     cur_q <= next_idx;
                     dly_q <= '0;
                  end else begin
                     dly_q <= dly_q + 1'b1;
                  end
               end
            end
            default: phase_q <= PH_OFF;
         endcase
      end
   end

   assign sample_stb = run && tick && (phase_q == PH_SCAN) && any
                       && last_tick && mask[cur_q];
   assign cur = cur_q;

endmodule

// File: rtl/rrs_result_bank.sv
// Per-channel result bit and sticky changed flag, plus interrupt.
module rrs_result_bank #(
   parameter int NUM_CH = 8,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_stb,
   input  logic [CH_W-1:0]   sample_ch,
   input  logic              sample_val,
   input  logic [NUM_CH-1:0] flag_clr,
   input  logic              irq_en,
   output logic [NUM_CH-1:0] result,
   output logic [NUM_CH-1:0] chg_flag,
   output logic              irq
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      logic res_q;
      logic flg_q;

      assign hit = sample_stb && (sample_ch == CH_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_q <= 1'b0;
            flg_q <= 1'b0;
         end else begin
            if (hit) res_q <= sample_val;
            // a set in the same clock overrides the clear
            flg_q <= (flg_q && !flag_clr[i]) || (hit && (sample_val != res_q));
         end
      end

      assign result[i]   = res_q;
      assign chg_flag[i] = flg_q;
   end

   assign irq = irq_en && (|chg_flag);

endmodule

// File: rtl/rr_cmp_scanner.sv
module rr_cmp_scanner
   import rrs_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DLY_W  = 2,
   parameter int INIT_W = 6,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rr_tick,
   input  logic              scan_en,
   input  logic [NUM_CH-1:0] ch_mask,
   input  logic [CH_W-1:0]   ref_ch,
   input  logic              hold_minus,
   input  logic [DLY_W-1:0]  settle,
   input  logic [INIT_W-1:0] init_mod,
   input  logic              cmp_in,
   input  logic              irq_en,
   input  logic [NUM_CH-1:0] flag_clr,
   output logic [CH_W-1:0]   plus_sel,
   output logic [CH_W-1:0]   minus_sel,
   output logic [NUM_CH-1:0] result,
   output logic [NUM_CH-1:0] chg_flag,
   output logic              irq
);
   // elaboration-time parameter checks
   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("rr_cmp_scanner: NUM_CH must be a power of two of at least 2");
   end
   if (DLY_W < 1 || INIT_W < 1) begin : g_bad_w
      $error("rr_cmp_scanner: DLY_W and INIT_W must be at least 1");
   end

   logic            init_ready;
   logic [CH_W-1:0] first_idx;
   logic [CH_W-1:0] next_idx;
   logic            any_en;
   logic [CH_W-1:0] sweep_ch;
   logic            sample_stb;
   hold_e           hold_sel;

   rrs_init_timer #(.INIT_W(INIT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (rr_tick),
      .run      (scan_en),
      .init_mod (init_mod),
      .ready    (init_ready)
   );

   rrs_picker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
      .mask      (ch_mask),
      .cur       (sweep_ch),
      .first_idx (first_idx),
      .next_idx  (next_idx),
      .any       (any_en)
   );

   rrs_sequencer #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DLY_W(DLY_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (rr_tick),
      .run        (scan_en),
      .ready      (init_ready),
      .mask       (ch_mask),
      .settle     (settle),
      .first_idx  (first_idx),
      .next_idx   (next_idx),
      .any        (any_en),
      .cur        (sweep_ch),
      .sample_stb (sample_stb)
   );

   rrs_result_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_stb (sample_stb),
      .sample_ch  (sweep_ch),
      .sample_val (cmp_in),
      .flag_clr   (flag_clr),
      .irq_en     (irq_en),
      .result     (result),
      .chg_flag   (chg_flag),
      .irq        (irq)
   );

   // port routing: one port pinned to the reference, the other swept
   assign hold_sel = hold_e'(hold_minus);

   always_comb begin
      if (hold_sel == HOLD_MINUS) begin
         minus_sel = ref_ch;
         plus_sel  = sweep_ch;
      end else begin
         plus_sel  = ref_ch;
         minus_sel = sweep_ch;
      end
   end

endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rr_tick,
   input logic              scan_en,
   input logic [NUM_CH-1:0] ch_mask,
   input logic [NUM_CH-1:0] result,
   input logic [NUM_CH-1:0] chg_flag,
   input logic [CH_W-1:0]   sweep_ch
);
   a_r1_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> $stable(result));

   a_r5_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !rr_tick |=> $stable(sweep_ch));

   a_r6_one_bit_per_clock: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(result ^ $past(result)));

   a_r7_change_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ((result ^ $past(result)) & ~chg_flag) == '0);

   a_r10_empty_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mask == '0) |=> ($stable(result) && $stable(sweep_ch)));

endmodule

bind rr_cmp_scanner rrs_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rr_tick  (rr_tick),
   .scan_en  (scan_en),
   .ch_mask  (ch_mask),
   .result   (result),
   .chg_flag (chg_flag),
   .sweep_ch (sweep_ch)
);

// File: tb/test_rr_cmp_scanner.sv
`timescale 1ns/1ps
module test_rr_cmp_scanner;
   localparam int NUM_CH = 8;
   localparam int CH_W   = 3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              rr_tick;
   logic              scan_en;
   logic [NUM_CH-1:0] ch_mask;
   logic [CH_W-1:0]   ref_ch;
   logic              hold_minus;
   logic [1:0]        settle;
   logic [5:0]        init_mod;
   logic              cmp_in;
   logic              irq_en;
   logic [NUM_CH-1:0] flag_clr;
   logic [CH_W-1:0]   plus_sel;
   logic [CH_W-1:0]   minus_sel;
   logic [NUM_CH-1:0] result;
   logic [NUM_CH-1:0] chg_flag;
   logic              irq;

   int checks = 0;
   int fails  = 0;
   logic [7:0]  exp_res;
   logic [7:0]  exp_flg;
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   rr_cmp_scanner i_rr_cmp_scanner (
      .clk(clk), .rst_n(rst_n), .rr_tick(rr_tick), .scan_en(scan_en),
      .ch_mask(ch_mask), .ref_ch(ref_ch), .hold_minus(hold_minus),
      .settle(settle), .init_mod(init_mod), .cmp_in(cmp_in), .irq_en(irq_en),
      .flag_clr(flag_clr), .plus_sel(plus_sel), .minus_sel(minus_sel),
      .result(result), .chg_flag(chg_flag), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int popc(input logic [7:0] m);
      int n = 0;
      for (int i = 0; i < 8; i++) n += int'(m[i]);
      return n;
   endfunction

   // channel of the v-th visit (0-based) in ascending wrap order
   function automatic int nth_ch(input logic [7:0] m, input int v);
      int idx = v % popc(m);
      int seen = 0;
      int ch = 0;
      for (int i = 0; i < 8; i++) begin
         if (m[i]) begin
            if (seen == idx) ch = i;
            seen++;
         end
      end
      return ch;
   endfunction

   task automatic step(input logic cv, input logic [7:0] clr);
      @(negedge clk);
      rr_tick = 1'b1; cmp_in = cv; flag_clr = clr;
      @(negedge clk);
      rr_tick = 1'b0; flag_clr = '0;
   endtask

   function automatic int sweep_port();
      return hold_minus ? int'(plus_sel) : int'(minus_sel);
   endfunction

   function automatic int fixed_port();
      return hold_minus ? int'(minus_sel) : int'(plus_sel);
   endfunction

   task automatic check_outputs();
      chk("R6 result", int'(result), int'(exp_res));
      chk("R7 R8 flags", int'(chg_flag), int'(exp_flg));
      chk("R9 irq", int'(irq), int'(irq_en && (exp_flg != 0)));
      chk("R4 fixed port", fixed_port(), int'(ref_ch));
   endtask

   task automatic run_cfg(input logic [7:0] m, input int s, input int im,
                          input logic hm, input int rc, input logic ie);
      int M = (im == 0) ? 64 : im;
      int n_ticks = M + 1 + (s + 1) * (2 * popc(m) + 1);
      @(negedge clk);
      scan_en = 1'b0; ch_mask = m; settle = 2'(s); init_mod = 6'(im);
      hold_minus = hm; ref_ch = 3'(rc); irq_en = ie; flag_clr = 8'hFF;
      @(negedge clk);
      flag_clr = '0; exp_flg = '0;
      scan_en = 1'b1;
      for (int k = 1; k <= n_ticks; k++) begin
         logic cv;
         logic [7:0] clr;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cv  = lfsr[0];
         clr = (k % 5 == 3) ? lfsr[8:1] : 8'h00;
         step(cv, clr);
         exp_flg = exp_flg & ~clr;
         if (k > M + 1 && ((k - M - 1) % (s + 1)) == 0) begin
            int ch = nth_ch(m, (k - M - 1) / (s + 1) - 1);
            if (cv != exp_res[ch]) exp_flg[ch] = 1'b1;
            exp_res[ch] = cv;
         end
         check_outputs();
         if (k == M + 1) begin
            if (im == 0) chk("R12 full modulus start", sweep_port(), nth_ch(m, 0));
            else         chk("R2 first channel after wait", sweep_port(), nth_ch(m, 0));
         end
         if (k >= M + 1)
            chk("R3 R5 sweep order", sweep_port(), nth_ch(m, (k - M - 1) / (s + 1)));
      end
      // disabled: ticks must not touch results
      @(negedge clk);
      scan_en = 1'b0;
      for (int k = 0; k < 3; k++) begin
         step(~exp_res[k], 8'h00);
         chk("R1 idle when disabled", int'(result), int'(exp_res));
      end
   endtask

   initial begin
      rst_n = 1'b0; rr_tick = 1'b0; scan_en = 1'b0; ch_mask = '0;
      ref_ch = '0; hold_minus = 1'b0; settle = '0; init_mod = 6'd1;
      cmp_in = 1'b0; irq_en = 1'b1; flag_clr = '0;
      exp_res = '0; exp_flg = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset result", int'(result), 0);
      chk("R11 reset flags", int'(chg_flag), 0);
      chk("R11 reset irq", int'(irq), 0);
      chk("R11 reset sweep select", int'(minus_sel), 0);
      chk("R11 reset fixed select", int'(plus_sel), 0);

      for (int mi = 0; mi < 3; mi++) begin
         for (int s = 0; s < 4; s++) begin
            for (int mk = 0; mk < 5; mk++) begin
               logic [7:0] m;
               int im;
               case (mk)
                  0: m = 8'h01;
                  1: m = 8'hA5;
                  2: m = 8'hFF;
                  3: m = 8'h80;
                  default: m = 8'h3C;
               endcase
               im = (mi == 0) ? 1 : (mi == 1) ? 3 : 0;
               run_cfg(m, s, im, 1'((mk + s) % 2), (mk * 3 + s) % 8, 1'(mk % 2 == 0));
            end
         end
      end

      // empty mask: nothing moves
      begin
         int sw_before;
         @(negedge clk);
         ch_mask = '0; init_mod = 6'd1; settle = 2'd0; scan_en = 1'b1;
         sw_before = sweep_port();
         for (int k = 0; k < 10; k++) begin
            step(k[0], 8'h00);
            chk("R10 empty mask result", int'(result), int'(exp_res));
            chk("R10 empty mask flags", int'(chg_flag), int'(exp_flg));
            chk("R10 empty mask sweep", sweep_port(), sw_before);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #750000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule